// File: doc/BRIEF.md
# Scaled-Index Effective Address Calculator

This block forms the effective address of a memory operand for a processor with variable-length instructions and eight 32-bit general registers. The instruction decoder presents the following fields:

- an addressing-mode code;
- the numbers of a base register and an index register;
- a 2-bit scale code;
- a displacement, with a flag that says whether it is 8 or 32 bits wide;
- a 32-bit absolute location.

The block sends the two register numbers out on two combinational read ports. The register file returns the two values in the same cycle. One clock later the block presents three results: the address, a flag that marks a register-direct operand, and a flag that marks an illegal encoding.

The block adds the terms that the selected mode uses:

- the base value;
- the index value shifted left by the scale code;
- the sign-extended displacement;
- or the absolute location.

All sums wrap modulo 2^32. An encoding that names the stack pointer as an index, or that gives a short displacement where only the long form is allowed, raises the illegal flag and forces the address to zero. Instruction-byte parsing, segmentation and the memory access itself are handled elsewhere.

Top module: `scaled_ea_unit`

## Requirements
- R1: While reset is low, and after it rises until the first capture, the address is 0 and both flags are 0.
- R2: The outputs reflect the inputs and read-port values present at the previous rising clock edge: one cycle of latency.
- R3: The scaled index equals the index value shifted left by the scale code: codes 0, 1, 2 and 3 multiply by 1, 2, 4 and 8.
- R4: When the long flag is 0, bits [7:0] of the displacement input are sign-extended to 32 bits and the upper bits are ignored. When the long flag is 1, all 32 bits are used.
- R5: Mode code 6 (base, index, displacement) gives base + scaled index + displacement modulo 2^32.
- R6: Mode code 5 (base and index) gives base + scaled index, and the displacement has no effect.
- R7: Mode code 7 (index and displacement, no base) gives scaled index + 32-bit displacement, and the base register has no effect.
- R8: In mode codes 5, 6 and 7, index register number 4 (the stack pointer) sets the illegal flag and gives address 0. Register 4 used as a base stays legal.
- R9: Mode code 7 with the long flag at 0 sets the illegal flag and gives address 0.
- R10: Mode code 2 (register operand) sets the register flag, clears the illegal flag and drives address 0.
- R11: Mode code 1 (direct) gives the absolute location. Mode code 3 (register indirect) gives the base value. Mode code 4 gives base + displacement, in either displacement size.
- R12: Mode code 0 (immediate) gives address 0 with both flags clear. In modes 0 to 4 the index register and scale have no effect, and register 4 as an index is not illegal.
- R13: The base and index read-port selects equal the base and index register numbers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Addressing-mode code, 0 to 7 |
| base_num_i | input | 3 | Base register number |
| index_num_i | input | 3 | Index register number |
| scale_i | input | 2 | Scale code (shift amount) |
| disp_i | input | 32 | Displacement; only bits [7:0] are used in short form |
| disp_long_i | input | 1 | 1 selects the 32-bit displacement, 0 the 8-bit one |
| abs_loc_i | input | 32 | Absolute location for direct mode |
| base_sel_o | output | 3 | Read-port select for the base register |
| index_sel_o | output | 3 | Read-port select for the index register |
| base_val_i | input | 32 | Value returned for the base select |
| index_val_i | input | 32 | Value returned for the index select |
| ea_o | output | 32 | Registered effective address |
| op_is_reg_o | output | 1 | Registered flag: the operand is the register itself |
| illegal_o | output | 1 | Registered flag: illegal encoding |

## Verification
The checker watches several rules on every cycle:

- an illegal flag always comes with a zero address;
- a stack-pointer index in an indexed mode, or a short displacement in the baseless indexed mode, is flagged one cycle later;
- register mode raises only the register flag;
- direct and register-indirect addresses follow the location and base inputs one cycle later.

The arithmetic itself can only be shown by the bench's scenarios. These include:

- every scale code;
- sign extension at the 0x7F/0x80 edge;
- wrap-around of the three-term sum;
- displacement or base inputs with no effect in the modes that ignore them;
- a legal stack-pointer base;
- random mixes of all modes checked against a bench model.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic [2:0] {
      EAM_IMMED     = 3'd0,
      EAM_DIRECT    = 3'd1,
      EAM_REGISTER  = 3'd2,
      EAM_REG_IND   = 3'd3,
      EAM_BASE_DISP = 3'd4,
      EAM_BASE_IDX  = 3'd5,
      EAM_FULL      = 3'd6,
      EAM_IDX_DISP  = 3'd7
   } ea_mode_e;

   // Which terms a mode feeds into the adder, plus the two flags.
   typedef struct packed {
      logic use_base;
      logic use_index;
      logic use_disp;
      logic use_abs;
      logic op_reg;
      logic illegal;
   } ea_ctl_t;

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode import ea_pkg::*; #(
   parameter int NREG   = 8,
   parameter int SP_REG = 4,
   localparam int REG_W = $clog2(NREG)
) (
   input  logic [2:0]       mode,
   input  logic [REG_W-1:0] index_num,
   input  logic             disp_long,
   output ea_ctl_t          ctl
);

   logic idx_is_sp;
   assign idx_is_sp = (index_num == REG_W'(SP_REG));

   always_comb begin
      ctl = '0;
      unique case (ea_mode_e'(mode))
         EAM_IMMED:     ctl = '0;
         EAM_DIRECT:    ctl.use_abs = 1'b1;
         EAM_REGISTER:  ctl.op_reg  = 1'b1;
         EAM_REG_IND:   ctl.use_base = 1'b1;
         EAM_BASE_DISP: begin
            ctl.use_base = 1'b1;
            ctl.use_disp = 1'b1;
         end
         EAM_BASE_IDX: begin
            ctl.use_base  = 1'b1;
            ctl.use_index = 1'b1;
            ctl.illegal   = idx_is_sp;
         end
         EAM_FULL: begin
            ctl.use_base  = 1'b1;
            ctl.use_index = 1'b1;
            ctl.use_disp  = 1'b1;
            ctl.illegal   = idx_is_sp;
         end
         EAM_IDX_DISP: begin
            ctl.use_index = 1'b1;
            ctl.use_disp  = 1'b1;
            ctl.illegal   = idx_is_sp | ~disp_long;
         end
         default:       ctl = '0;
      endcase
   end

endmodule

// File: rtl/ea_disp_extend.sv
module ea_disp_extend #(
   parameter int ADDR_W  = 32,
   parameter int SHORT_W = 8
) (
   input  logic [ADDR_W-1:0] raw,
   input  logic              long_form,
   output logic [ADDR_W-1:0] value
);

   logic [ADDR_W-1:0] short_ext;

   generate
      if (SHORT_W >= ADDR_W) begin : g_no_ext
         assign short_ext = raw;
      end else begin : g_ext
         assign short_ext = {{(ADDR_W-SHORT_W){raw[SHORT_W-1]}}, raw[SHORT_W-1:0]};
      end
   endgenerate

   assign value = long_form ? raw : short_ext;

endmodule

// File: rtl/ea_index_scaler.sv
module ea_index_scaler #(
   parameter int ADDR_W  = 32,
   parameter int SCALE_W = 2,
   parameter bit USE_MUX = 1'b0
) (
   input  logic [ADDR_W-1:0]  index_val,
   input  logic [SCALE_W-1:0] scale,
   output logic [ADDR_W-1:0]  scaled
);

   localparam int NSCALE = 1 << SCALE_W;

   generate
      if (USE_MUX) begin : g_mux
         // One pre-shifted copy per scale code, then a select.
         logic [ADDR_W-1:0] shifted [NSCALE];
         for (genvar s = 0; s < NSCALE; s++) begin : g_tap
            assign shifted[s] = index_val << s;
         end
         assign scaled = shifted[scale];
      end else begin : g_shift
         assign scaled = index_val << scale;
      end
   endgenerate

endmodule

// File: rtl/ea_sum3.sv
module ea_sum3 #(
   parameter int ADDR_W  = 32,
   parameter bit USE_CSA = 1'b1
) (
   input  logic [ADDR_W-1:0] a,
   input  logic [ADDR_W-1:0] b,
   input  logic [ADDR_W-1:0] c,
   output logic [ADDR_W-1:0] sum
);

   generate
      if (USE_CSA) begin : g_csa
         logic [ADDR_W-1:0] partial;
         logic [ADDR_W-1:0] carries;
         assign partial = a ^ b ^ c;
         assign carries = ((a & b) | (a & c) | (b & c)) << 1;
         assign sum     = partial + carries;
      end else begin : g_chain
         assign sum = a + b + c;
      end
   endgenerate

endmodule

// File: rtl/scaled_ea_unit.sv
module scaled_ea_unit import ea_pkg::*; #(
   parameter int ADDR_W       = 32,
   parameter int NREG         = 8,
   parameter int SHORT_DISP_W = 8,
   parameter int SCALE_W      = 2,
   parameter int SP_REG       = 4,
   parameter bit SCALE_MUX    = 1'b0,
   parameter bit ADD_CSA      = 1'b1,
   localparam int REG_W       = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         mode_i,
   input  logic [REG_W-1:0]   base_num_i,
   input  logic [REG_W-1:0]   index_num_i,
   input  logic [SCALE_W-1:0] scale_i,
   input  logic [ADDR_W-1:0]  disp_i,
   input  logic               disp_long_i,
   input  logic [ADDR_W-1:0]  abs_loc_i,
   output logic [REG_W-1:0]   base_sel_o,
   output logic [REG_W-1:0]   index_sel_o,
   input  logic [ADDR_W-1:0]  base_val_i,
   input  logic [ADDR_W-1:0]  index_val_i,
   output logic [ADDR_W-1:0]  ea_o,
   output logic               op_is_reg_o,
   output logic               illegal_o
);

   // Elaboration-time parameter checks
   generate
      if (ADDR_W <= SHORT_DISP_W) begin : g_bad_width
         $error("ADDR_W must exceed SHORT_DISP_W");
      end
      if (NREG < 2 || (1 << REG_W) != NREG) begin : g_bad_nreg
         $error("NREG must be a power of two, at least 2");
      end
      if (SP_REG < 0 || SP_REG >= NREG) begin : g_bad_sp
         $error("SP_REG must name an existing register");
      end
      if (SCALE_W < 1 || SCALE_W > 3) begin : g_bad_scale
         $error("SCALE_W must be 1 to 3");
      end
   endgenerate

   // Register file read ports
   assign base_sel_o  = base_num_i;
   assign index_sel_o = index_num_i;

   ea_ctl_t           ctl;
   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] index_scaled;
   logic [ADDR_W-1:0] term_base;
   logic [ADDR_W-1:0] term_index;
   logic [ADDR_W-1:0] term_disp;
   logic [ADDR_W-1:0] term_sum;
   logic [ADDR_W-1:0] ea_next;

   ea_mode_decode #(
      .NREG   (NREG),
      .SP_REG (SP_REG)
   ) u_decode (
      .mode      (mode_i),
      .index_num (index_num_i),
      .disp_long (disp_long_i),
      .ctl       (ctl)
   );

   ea_disp_extend #(
      .ADDR_W  (ADDR_W),
      .SHORT_W (SHORT_DISP_W)
   ) u_disp (
      .raw       (disp_i),
      .long_form (disp_long_i),
      .value     (disp_ext)
   );

   ea_index_scaler #(
      .ADDR_W  (ADDR_W),
      .SCALE_W (SCALE_W),
      .USE_MUX (SCALE_MUX)
   ) u_scale (
      .index_val (index_val_i),
      .scale     (scale_i),
      .scaled    (index_scaled)
   );

   assign term_base  = ctl.use_base  ? base_val_i   : '0;
   assign term_index = ctl.use_index ? index_scaled : '0;
   assign term_disp  = ctl.use_disp  ? disp_ext     : '0;

   ea_sum3 #(
      .ADDR_W  (ADDR_W),
      .USE_CSA (ADD_CSA)
   ) u_sum (
      .a   (term_base),
      .b   (term_index),
      .c   (term_disp),
      .sum (term_sum)
   );

   always_comb begin
      if (ctl.illegal)      ea_next = '0;
      else if (ctl.use_abs) ea_next = abs_loc_i;
      else                  ea_next = term_sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_o        <= '0;
         op_is_reg_o <= 1'b0;
         illegal_o   <= 1'b0;
      end else begin
         ea_o        <= ea_next;
         op_is_reg_o <= ctl.op_reg;
         illegal_o   <= ctl.illegal;
      end
   end

endmodule

// File: rtl/scaled_ea_unit_chk.sv
module scaled_ea_unit_chk #(
   parameter int ADDR_W = 32,
   parameter int NREG   = 8,
   parameter int SP_REG = 4,
   localparam int REG_W = $clog2(NREG)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mode_i,
   input logic [REG_W-1:0]  index_num_i,
   input logic              disp_long_i,
   input logic [ADDR_W-1:0] abs_loc_i,
   input logic [ADDR_W-1:0] base_val_i,
   input logic [ADDR_W-1:0] ea_o,
   input logic              op_is_reg_o,
   input logic              illegal_o
);

   logic indexed_mode;
   assign indexed_mode = (mode_i == 3'd5) || (mode_i == 3'd6) || (mode_i == 3'd7);

   assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (ea_o == '0) && !op_is_reg_o);

   assert_sp_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (indexed_mode && index_num_i == REG_W'(SP_REG)) |=> illegal_o);

   assert_short_disp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd7 && !disp_long_i) |=> illegal_o);

   assert_register_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd2) |=> op_is_reg_o && !illegal_o);

   assert_direct_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd1) |=> ea_o == $past(abs_loc_i));

   assert_indirect_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd3) |=> ea_o == $past(base_val_i));

   assert_legal_plain_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd0 || mode_i == 3'd4) |=> !illegal_o && !op_is_reg_o);

endmodule

bind scaled_ea_unit scaled_ea_unit_chk #(
   .ADDR_W (ADDR_W),
   .NREG   (NREG),
   .SP_REG (SP_REG)
) u_chk (.*);

// File: tb/test_scaled_ea_unit.sv
`timescale 1ns/1ps
module test_scaled_ea_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_i = '0;
   logic [2:0]  base_num_i = '0;
   logic [2:0]  index_num_i = '0;
   logic [1:0]  scale_i = '0;
   logic [31:0] disp_i = '0;
   logic        disp_long_i = 1'b0;
   logic [31:0] abs_loc_i = '0;
   logic [2:0]  base_sel_o;
   logic [2:0]  index_sel_o;
   logic [31:0] base_val_i;
   logic [31:0] index_val_i;
   logic [31:0] ea_o;
   logic        op_is_reg_o;
   logic        illegal_o;

   logic [31:0] rf [8];
   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;   // 250 MHz

   // Register file model answers on the read-port selects (R13)
   assign base_val_i  = rf[base_sel_o];
   assign index_val_i = rf[index_sel_o];

   scaled_ea_unit i_scaled_ea_unit (.*);

   function automatic logic [33:0] model(input logic [2:0] m, input logic [2:0] b,
                                         input logic [2:0] x, input logic [1:0] sc,
                                         input logic [31:0] d, input logic dl,
                                         input logic [31:0] ab);
      logic [31:0] bv, xs, dx;
      bv = rf[b];
      xs = rf[x] << sc;
      dx = dl ? d : {{24{d[7]}}, d[7:0]};
      case (m)
         3'd0: return {32'd0, 2'b00};
         3'd1: return {ab, 2'b00};
         3'd2: return {32'd0, 2'b10};
         3'd3: return {bv, 2'b00};
         3'd4: return {bv + dx, 2'b00};
         3'd5: return (x == 3'd4) ? {32'd0, 2'b01} : {bv + xs, 2'b00};
         3'd6: return (x == 3'd4) ? {32'd0, 2'b01} : {bv + xs + dx, 2'b00};
         default: return (x == 3'd4 || !dl) ? {32'd0, 2'b01} : {xs + dx, 2'b00};
      endcase
   endfunction

   task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual ea=%h reg=%b ill=%b expected ea=%h reg=%b ill=%b",
                  req, act[33:2], act[1], act[0], exp[33:2], exp[1], exp[0]);
      end
   endtask

   task automatic run(input string req, input logic [2:0] m, input logic [2:0] b,
                      input logic [2:0] x, input logic [1:0] sc, input logic [31:0] d,
                      input logic dl, input logic [31:0] ab);
      logic [33:0] exp;
      @(negedge clk);
      mode_i = m; base_num_i = b; index_num_i = x; scale_i = sc;
      disp_i = d; disp_long_i = dl; abs_loc_i = ab;
      exp = model(m, b, x, sc, d, dl, ab);
      #0.5;
      checks++;
      if (base_sel_o !== b || index_sel_o !== x) begin
         errors++;
         $display("FAIL R13: actual sel=%0d/%0d expected %0d/%0d", base_sel_o, index_sel_o, b, x);
      end
      @(posedge clk);
      #1;
      check(req, {ea_o, op_is_reg_o, illegal_o}, exp);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int r = 0; r < 8; r++) rf[r] = 32'h100 * (r + 1);
      mode_i = 3'd1; abs_loc_i = 32'hDEAD_BEEF;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset", {ea_o, op_is_reg_o, illegal_o}, 34'd0);
      @(negedge clk); rst_n = 1'b1;
      #0.5;
      check("R1 after release", {ea_o, op_is_reg_o, illegal_o}, 34'd0);

      // R3: each scale code
      rf[1] = 32'h0000_1000; rf[2] = 32'h0000_0003;
      for (int s = 0; s < 4; s++)
         run("R3 scale", 3'd5, 3'd1, 3'd2, 2'(s), 32'h0, 1'b0, 32'h0);
      // R4: sign extension edges, upper bits ignored in short form
      run("R4 short +127", 3'd4, 3'd1, 3'd0, 2'd0, 32'hFFFF_FF7F, 1'b0, 32'h0);
      run("R4 short -128", 3'd4, 3'd1, 3'd0, 2'd0, 32'h0000_0080, 1'b0, 32'h0);
      run("R4 long", 3'd4, 3'd1, 3'd0, 2'd0, 32'h0000_0080, 1'b1, 32'h0);
      // R5: full mode with wrap
      rf[3] = 32'hFFFF_FFF0; rf[5] = 32'h0000_0004;
      run("R5 full wrap", 3'd6, 3'd3, 3'd5, 2'd3, 32'h0000_0080, 1'b0, 32'h0);
      run("R5 full long", 3'd6, 3'd3, 3'd5, 2'd2, 32'h1234_5678, 1'b1, 32'h0);
      // R6: displacement has no effect
      run("R6 no disp a", 3'd5, 3'd1, 3'd5, 2'd1, 32'h0000_0011, 1'b1, 32'h0);
      run("R6 no disp b", 3'd5, 3'd1, 3'd5, 2'd1, 32'hFFFF_0000, 1'b0, 32'h0);
      // R7: base has no effect
      run("R7 idx disp", 3'd7, 3'd3, 3'd5, 2'd2, 32'h0000_1000, 1'b1, 32'h0);
      run("R7 other base", 3'd7, 3'd6, 3'd5, 2'd2, 32'h0000_1000, 1'b1, 32'h0);
      // R8: stack-pointer index
      run("R8 sp idx m5", 3'd5, 3'd1, 3'd4, 2'd1, 32'h0, 1'b0, 32'h0);
      run("R8 sp idx m6", 3'd6, 3'd1, 3'd4, 2'd0, 32'h8, 1'b1, 32'h0);
      run("R8 sp idx m7", 3'd7, 3'd1, 3'd4, 2'd0, 32'h8, 1'b1, 32'h0);
      run("R8 sp base legal", 3'd4, 3'd4, 3'd0, 2'd0, 32'h4, 1'b0, 32'h0);
      run("R8 sp base full", 3'd6, 3'd4, 3'd2, 2'd1, 32'h4, 1'b0, 32'h0);
      // R9
      run("R9 short in m7", 3'd7, 3'd1, 3'd2, 2'd0, 32'h10, 1'b0, 32'h0);
      // R10
      run("R10 register", 3'd2, 3'd1, 3'd2, 2'd3, 32'h55, 1'b1, 32'h77);
      // R11
      run("R11 direct", 3'd1, 3'd1, 3'd4, 2'd0, 32'h0, 1'b0, 32'hCAFE_0123);
      run("R11 indirect", 3'd3, 3'd3, 3'd4, 2'd3, 32'h99, 1'b1, 32'h0);
      run("R11 base disp neg", 3'd4, 3'd1, 3'd7, 2'd3, 32'h0000_00F0, 1'b0, 32'h0);
      // R12
      run("R12 immediate", 3'd0, 3'd1, 3'd4, 2'd3, 32'hFF, 1'b0, 32'h1234);
      run("R12 sp idx ignored", 3'd3, 3'd1, 3'd4, 2'd3, 32'h0, 1'b0, 32'h0);

      // Random mix across all modes (R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12)
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         for (int r = 0; r < 8; r++) rf[r] = $urandom;
         run("R2 random", 3'($urandom), 3'($urandom), 3'($urandom), 2'($urandom),
             $urandom, 1'($urandom), $urandom);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule